// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block extends a core's private data cache for a hardware transactional memory that buffers new values locally until commit and detects conflicts only when another core commits. Every word of the cache carries three flags: a valid flag, a read flag that marks the word as part of the current read set, and a write flag that marks it as part of the speculative write set. Stores made inside a transaction overwrite the cached word in place and stay private. Loads made inside a transaction record which words were read.

Other cores' commits arrive on a snoop port as a word address together with the committed data. If the snooped address falls on a word that the local transaction has read, the block raises a sticky violation flag. The snooped data also refreshes the local copy of any word that is not being written speculatively.

When the core asks to commit, the write set streams out as one (address, data) pair per cycle in ascending address order, and the stream marks its final pair. An abort takes a single cycle: it invalidates the speculatively written words and clears all read and write flags. The cache array is indexed directly by word address, so it has no tags and no replacement.

Top module: `txc_conflict_tracker`

## Requirements
- R1: After reset no transaction is open (`tx_active`=0), `violation`=0, `ws_valid`=0, and every word is invalid, so a load of any address returns 0.
- R2: A store accepted while a transaction is open (`tx_active`=1) makes the word valid and write-marked, and later loads of that word return the stored value. A store issued while no transaction is open changes nothing.
- R3: A load of a word whose write flag is clear returns the word's data if it is valid and 0 if it is not. Inside an open transaction that load also sets the word's read flag. A load of a write-marked word returns the speculative value and does not set the read flag.
- R4: A snoop (`snp_valid`=1) presented during an open transaction, whose word address has its read flag set, drives `violation` to 1 in the next cycle. The flag stays at 1 until the transaction ends. A snoop of any word whose read flag is clear leaves `violation` unchanged.
- R5: A snoop writes `snp_data` into the addressed word and makes it valid unless that word is write-marked. A write-marked word keeps its speculative value.
- R6: `tx_abort` during an open transaction returns the block to idle in one cycle. In that cycle it invalidates every write-marked word, clears all read and write flags, and clears `violation`. `tx_abort` takes priority over `tx_commit` presented in the same cycle.
- R7: `tx_commit` during an open transaction with `violation`=0 starts the write-set stream in the following cycle. The stream emits one write-marked word per cycle in ascending address order on `ws_addr`/`ws_data` with `ws_valid`=1. `ws_last`=1 and `cmt_done`=1 mark the highest such word. If the write set is empty, the stream emits only a single `cmt_done` cycle with `ws_valid`=0.
- R8: When the stream finishes, all read and write flags are cleared and the valid flags are kept. Committed words then read back their values, and the block returns to idle.
- R9: `tx_commit` while `violation`=1 behaves exactly as `tx_abort`: nothing is streamed.
- R10: Every load request is answered one cycle later with `core_rvalid`=1 and the data on `core_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction (accepted only when idle) |
| tx_commit | input | 1 | Request commit of the open transaction |
| tx_abort | input | 1 | Abort the open transaction |
| core_req | input | 1 | Core access request |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Word address of the access |
| core_wdata | input | DATA_W | Store data |
| core_rdata | output | DATA_W | Load data, one cycle after the request |
| core_rvalid | output | 1 | Load data valid |
| snp_valid | input | 1 | Remote commit word present |
| snp_addr | input | ADDR_W | Remote committed word address |
| snp_data | input | DATA_W | Remote committed word data |
| violation | output | 1 | Sticky read-set conflict flag |
| tx_active | output | 1 | A transaction is open (not committing) |
| ws_valid | output | 1 | Write-set stream word present |
| ws_addr | output | ADDR_W | Write-set word address |
| ws_data | output | DATA_W | Write-set word data |
| ws_last | output | 1 | Final word of the write-set stream |
| cmt_done | output | 1 | Commit stream completes this cycle |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=32, which gives a 16-word array (two 32-byte lines). With this size every pairing of a read word and a snooped word can be tried, 256 combinations in total. The small array also makes the edge cases of the write-set stream reachable: an empty set, a single word, the extreme words 0 and 15 only, and a completely written array. Expected loads, violations and stream contents come from a flag-level model of the requirements kept in the bench.

// File: rtl/txc_pkg.sv
package txc_pkg;

  // Transaction phase of the local core.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_COMMIT = 2'd2
  } txc_phase_e;

endpackage

// File: rtl/txc_word_flags.sv
module txc_word_flags #(
  parameter int NW = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_abort,
  input  logic          clear_rw,
  input  logic          rd_mark_en,
  input  logic [IW-1:0] rd_mark_idx,
  input  logic          wr_mark_en,
  input  logic [IW-1:0] wr_mark_idx,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  output logic [NW-1:0] r_bits,
  output logic [NW-1:0] w_bits,
  output logic [NW-1:0] v_bits
);

  logic [NW-1:0] r_nx, w_nx, v_nx;

  always_comb begin
    r_nx = r_bits;
    w_nx = w_bits;
    v_nx = v_bits;
    if (fill_en && !w_bits[fill_idx]) v_nx[fill_idx] = 1'b1;
    if (rd_mark_en) r_nx[rd_mark_idx] = 1'b1;
    if (wr_mark_en) begin
      w_nx[wr_mark_idx] = 1'b1;
      v_nx[wr_mark_idx] = 1'b1;
    end
    if (clear_rw) begin
      r_nx = '0;
      w_nx = '0;
    end
    if (flush_abort) begin
      v_nx = v_nx & ~w_bits;
      r_nx = '0;
      w_nx = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_bits <= '0;
      w_bits <= '0;
      v_bits <= '0;
    end else begin
      r_bits <= r_nx;
      w_bits <= w_nx;
      v_bits <= v_nx;
    end
  end

  // R6: one-cycle discard of the read and write sets
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_abort |=> (r_bits == '0) && (w_bits == '0));

  // R2: a write-marked word is always valid
  a_r2_w_implies_v: assert property (@(posedge clk) disable iff (!rst_n)
    (w_bits & ~v_bits) == '0);

  // R8: commit completion keeps valid words valid
  a_r8_commit_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_rw && !flush_abort) |=> ((v_bits & $past(v_bits)) == $past(v_bits)));

endmodule

// File: rtl/txc_word_store.sv
module txc_word_store #(
  parameter int NW = 64,
  parameter int IW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          st_en,
  input  logic [IW-1:0] st_idx,
  input  logic [DW-1:0] st_data,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic [DW-1:0] fill_data,
  input  logic [IW-1:0] rd_idx_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [IW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_data_b
);

  logic [DW-1:0] mem [NW];

  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (st_en && st_idx == IW'(i))
        mem[i] <= st_data;
      else if (fill_en && fill_idx == IW'(i))
        mem[i] <= fill_data;
    end
  end

  assign rd_data_a = mem[rd_idx_a];
  assign rd_data_b = mem[rd_idx_b];

endmodule

// File: rtl/txc_commit_stream.sv
module txc_commit_stream #(
  parameter int NW = 64,
  parameter int IW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [NW-1:0] w_bits,
  output logic [IW-1:0] rd_idx,
  input  logic [DW-1:0] rd_data,
  output logic          ws_valid,
  output logic [IW-1:0] ws_addr,
  output logic [DW-1:0] ws_data,
  output logic          ws_last,
  output logic          done
);

  localparam int PW = IW + 1;
  localparam logic [PW-1:0] NONE = PW'(NW);

  // Lowest set position at or above 'from', NONE if there is none.
  function automatic logic [PW-1:0] first_from(input logic [NW-1:0] bits,
                                               input logic [PW-1:0] from);
    logic [PW-1:0] res;
    res = NONE;
    for (int i = NW - 1; i >= 0; i--) begin
      if (bits[i] && PW'(i) >= from) res = PW'(i);
    end
    return res;
  endfunction

  logic [PW-1:0] ptr, cur, nxt;
  logic          found, last_w;

  assign cur    = first_from(w_bits, ptr);
  assign found  = (cur != NONE);
  assign nxt    = first_from(w_bits, cur + PW'(1));
  assign last_w = found && (nxt == NONE);

  assign rd_idx   = cur[IW-1:0];
  assign ws_valid = run && found;
  assign ws_addr  = cur[IW-1:0];
  assign ws_data  = rd_data;
  assign ws_last  = run && last_w;
  assign done     = run && (!found || last_w);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) ptr <= '0;
    else if (found)     ptr <= cur + PW'(1);
  end

  // R7: back-to-back ascending words until the final one
  a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_valid && !ws_last) |=> ws_valid && (ws_addr > $past(ws_addr)));

  // R7: the last marker coincides with completion
  a_r7_last_done: assert property (@(posedge clk) disable iff (!rst_n)
    ws_last |-> done && ws_valid);

endmodule

// File: rtl/txc_conflict_tracker.sv
module txc_conflict_tracker
  import txc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              tx_commit,
  input  logic              tx_abort,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_rvalid,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic              violation,
  output logic              tx_active,
  output logic              ws_valid,
  output logic [ADDR_W-1:0] ws_addr,
  output logic [DATA_W-1:0] ws_data,
  output logic              ws_last,
  output logic              cmt_done
);

  localparam int NW = 1 << ADDR_W;

  txc_phase_e phase;
  logic       viol_q;

  logic [NW-1:0]     r_bits, w_bits, v_bits;
  logic [DATA_W-1:0] rd_core, rd_stream;
  logic [ADDR_W-1:0] stream_idx;

  // Named internal events
  logic in_active, ending, do_abort, do_commit;
  logic core_ld, core_st, mark_r, snoop_fill, snoop_hit_r, stream_run, stream_done;

  assign in_active   = (phase == PH_ACTIVE);
  assign ending      = in_active && (tx_abort || tx_commit);
  assign do_abort    = in_active && (tx_abort || (tx_commit && viol_q));
  assign do_commit   = in_active && !tx_abort && tx_commit && !viol_q;
  assign core_ld     = core_req && !core_we;
  assign core_st     = core_req && core_we && in_active && !ending;
  assign mark_r      = core_ld && in_active && !ending && !w_bits[core_addr];
  assign snoop_fill  = snp_valid && !w_bits[snp_addr];
  assign snoop_hit_r = snp_valid && in_active && !ending && r_bits[snp_addr];
  assign stream_run  = (phase == PH_COMMIT);

  txc_word_flags #(.NW(NW), .IW(ADDR_W)) flags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_abort(do_abort),
    .clear_rw   (stream_done),
    .rd_mark_en (mark_r),
    .rd_mark_idx(core_addr),
    .wr_mark_en (core_st),
    .wr_mark_idx(core_addr),
    .fill_en    (snp_valid),
    .fill_idx   (snp_addr),
    .r_bits     (r_bits),
    .w_bits     (w_bits),
    .v_bits     (v_bits)
  );

  txc_word_store #(.NW(NW), .IW(ADDR_W), .DW(DATA_W)) store_i (
    .clk      (clk),
    .st_en    (core_st),
    .st_idx   (core_addr),
    .st_data  (core_wdata),
    .fill_en  (snoop_fill),
    .fill_idx (snp_addr),
    .fill_data(snp_data),
    .rd_idx_a (core_addr),
    .rd_data_a(rd_core),
    .rd_idx_b (stream_idx),
    .rd_data_b(rd_stream)
  );

  txc_commit_stream #(.NW(NW), .IW(ADDR_W), .DW(DATA_W)) stream_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (stream_run),
    .w_bits  (w_bits),
    .rd_idx  (stream_idx),
    .rd_data (rd_stream),
    .ws_valid(ws_valid),
    .ws_addr (ws_addr),
    .ws_data (ws_data),
    .ws_last (ws_last),
    .done    (stream_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:   if (tx_begin) phase <= PH_ACTIVE;
        PH_ACTIVE: if (do_abort) phase <= PH_IDLE;
                   else if (do_commit) phase <= PH_COMMIT;
        PH_COMMIT: if (stream_done) phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  viol_q <= 1'b0;
    else if (do_abort || (phase == PH_IDLE && tx_begin)) viol_q <= 1'b0;
    else if (snoop_hit_r)                        viol_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_rvalid <= 1'b0;
      core_rdata  <= '0;
    end else begin
      core_rvalid <= core_ld;
      if (core_ld) core_rdata <= v_bits[core_addr] ? rd_core : '0;
    end
  end

  assign violation = viol_q;
  assign tx_active = in_active;
  assign cmt_done  = stream_done;

  // R4: a read-set hit is flagged in the next cycle
  a_r4_hit_flags: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit_r |=> violation);

  // R7: the write-set stream only runs while committing
  a_r7_stream_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ws_valid |-> (phase == PH_COMMIT));

  // R9: a refused or aborted transaction streams nothing and is idle next
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    do_abort |=> !ws_valid && !tx_active && !violation);

  // R10: load answered one cycle later
  a_r10_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
    core_ld |=> core_rvalid);

  // R8: completion returns to idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_done |=> (phase == PH_IDLE));

endmodule

// File: tb/txc_conflict_tracker_tb_top.sv
module txc_conflict_tracker_tb_top;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tx_begin, tx_commit, tx_abort, core_req, core_we, snp_valid;
  logic [AW-1:0] core_addr, snp_addr;
  logic [DW-1:0] core_wdata, snp_data;
  logic [DW-1:0] core_rdata, ws_data;
  logic [AW-1:0] ws_addr;
  logic core_rvalid, violation, tx_active, ws_valid, ws_last, cmt_done;

  txc_conflict_tracker #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .tx_abort(tx_abort), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .core_rvalid(core_rvalid), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_data(snp_data), .violation(violation), .tx_active(tx_active),
    .ws_valid(ws_valid), .ws_addr(ws_addr), .ws_data(ws_data),
    .ws_last(ws_last), .cmt_done(cmt_done)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Flag-level model
  logic [DW-1:0] m_data [NW];
  logic [NW-1:0] m_v, m_r, m_w;
  logic          m_act, m_viol;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_open();
    tx_begin = 1'b1;
    @(negedge clk);
    tx_begin = 1'b0;
    m_act = 1'b1; m_viol = 1'b0; m_r = '0; m_w = '0;
  endtask

  task automatic do_store(input int a, input logic [DW-1:0] d);
    core_req = 1'b1; core_we = 1'b1; core_addr = AW'(a); core_wdata = d;
    @(negedge clk);
    core_req = 1'b0; core_we = 1'b0;
    if (m_act) begin
      m_data[a] = d; m_w[a] = 1'b1; m_v[a] = 1'b1;
    end
  endtask

  task automatic do_load(input int a, input string tag);
    logic [DW-1:0] exp;
    exp = m_v[a] ? m_data[a] : '0;
    core_req = 1'b1; core_we = 1'b0; core_addr = AW'(a);
    @(negedge clk);
    core_req = 1'b0;
    check($sformatf("R10 rvalid a=%0d", a), DW'(core_rvalid), 1);
    check($sformatf("%s load a=%0d", tag, a), core_rdata, exp);
    if (m_act && !m_w[a]) m_r[a] = 1'b1;
  endtask

  task automatic do_snoop(input int a, input logic [DW-1:0] d, input string tag);
    snp_valid = 1'b1; snp_addr = AW'(a); snp_data = d;
    @(negedge clk);
    snp_valid = 1'b0;
    if (m_act && m_r[a]) m_viol = 1'b1;
    if (!m_w[a]) begin
      m_data[a] = d; m_v[a] = 1'b1;
    end
    check($sformatf("%s violation snoop a=%0d", tag, a), DW'(violation), DW'(m_viol));
  endtask

  task automatic model_discard();
    m_v = m_v & ~m_w; m_r = '0; m_w = '0; m_viol = 1'b0; m_act = 1'b0;
  endtask

  task automatic do_abort(input string tag);
    tx_abort = 1'b1;
    @(negedge clk);
    tx_abort = 1'b0;
    model_discard();
    check({tag, " tx_active after abort"}, DW'(tx_active), 0);
    check({tag, " violation after abort"}, DW'(violation), 0);
  endtask

  task automatic do_commit(input string tag);
    int hi;
    tx_commit = 1'b1;
    @(negedge clk);
    tx_commit = 1'b0;
    if (m_viol) begin
      // R9: refused commit behaves as an abort
      model_discard();
      check({tag, " R9 no stream"}, DW'(ws_valid), 0);
      check({tag, " R9 idle"}, DW'(tx_active), 0);
      @(negedge clk);
      check({tag, " R9 still no stream"}, DW'(ws_valid | cmt_done), 0);
    end else begin
      hi = -1;
      for (int i = 0; i < NW; i++) if (m_w[i]) hi = i;
      if (hi < 0) begin
        check({tag, " R7 empty done"}, DW'(cmt_done), 1);
        check({tag, " R7 empty no valid"}, DW'(ws_valid), 0);
        @(negedge clk);
      end else begin
        for (int i = 0; i < NW; i++) begin
          if (m_w[i]) begin
            check($sformatf("%s R7 valid i=%0d", tag, i), DW'(ws_valid), 1);
            check($sformatf("%s R7 addr i=%0d", tag, i), DW'(ws_addr), DW'(i));
            check($sformatf("%s R7 data i=%0d", tag, i), ws_data, m_data[i]);
            check($sformatf("%s R7 last i=%0d", tag, i), DW'(ws_last), DW'(i == hi));
            check($sformatf("%s R7 done i=%0d", tag, i), DW'(cmt_done), DW'(i == hi));
            @(negedge clk);
          end
        end
      end
      m_r = '0; m_w = '0; m_act = 1'b0;
      check({tag, " R8 idle after commit"}, DW'(tx_active), 0);
      check({tag, " R7 stream stops"}, DW'(ws_valid), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_begin = 0; tx_commit = 0; tx_abort = 0;
    core_req = 0; core_we = 0; core_addr = '0; core_wdata = '0;
    snp_valid = 0; snp_addr = '0; snp_data = '0;
    m_v = '0; m_r = '0; m_w = '0; m_act = 0; m_viol = 0;
    for (int i = 0; i < NW; i++) m_data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 tx_active", DW'(tx_active), 0);
    check("R1 violation", DW'(violation), 0);
    check("R1 ws_valid", DW'(ws_valid), 0);
    for (int a = 0; a < NW; a++) do_load(a, "R1");

    // R2: store outside a transaction is ignored
    do_store(3, 32'hDEAD_0003);
    do_load(3, "R2 ignored store");

    // R2/R3: speculative stores on even words, loads everywhere
    tx_open();
    check("R2 tx_active", DW'(tx_active), 1);
    for (int a = 0; a < NW; a += 2) do_store(a, 32'hA000_0000 + DW'(a * 7));
    for (int a = 0; a < NW; a++) do_load(a, "R3");
    do_commit("commit even");
    for (int a = 0; a < NW; a++) do_load(a, "R8 committed");

    // R4/R3/R5: every read word against every snooped word
    for (int k = 0; k < NW; k++) begin
      for (int j = 0; j < NW; j++) begin
        tx_open();
        do_load(k, "R3 sweep");
        do_snoop(j, 32'h5000_0000 + DW'(k * 16 + j), "R4");
        do_snoop(j, 32'h6000_0000 + DW'(j), "R4 sticky");
        do_abort("R6 sweep");
      end
    end
    for (int a = 0; a < NW; a++) do_load(a, "R5 snoop filled");

    // R3/R5: write-marked word is not read-marked and keeps its value
    tx_open();
    do_store(5, 32'h0BAD_F00D);
    do_load(5, "R3 own write");
    do_snoop(5, 32'h1111_1111, "R3 no read mark");
    do_load(5, "R5 keeps speculative");
    do_abort("R6");
    do_load(5, "R6 invalidated");

    // R6: read set gone after abort
    tx_open();
    do_load(2, "R6 pre");
    do_abort("R6");
    tx_open();
    do_snoop(2, 32'h2222_2222, "R6 read set cleared");
    do_abort("R6");

    // R6: abort wins over commit in the same cycle
    tx_open();
    do_store(7, 32'h7777_0007);
    tx_abort = 1'b1; tx_commit = 1'b1;
    @(negedge clk);
    tx_abort = 1'b0; tx_commit = 1'b0;
    model_discard();
    check("R6 abort priority no stream", DW'(ws_valid), 0);
    check("R6 abort priority idle", DW'(tx_active), 0);
    do_load(7, "R6 abort priority");

    // R9: commit with violation pending
    tx_open();
    do_store(9, 32'h9999_0009);
    do_load(1, "R9 pre");
    do_snoop(1, 32'h0000_0101, "R9 set");
    do_commit("R9");
    do_load(9, "R9 discarded");

    // R7: empty write set
    tx_open();
    do_load(4, "R7 pre");
    do_commit("R7 empty");

    // R7: full write set
    tx_open();
    for (int a = 0; a < NW; a++) do_store(a, 32'hF000_0000 + DW'(a * 3 + 1));
    do_commit("R7 full");

    // R7: extreme words only
    tx_open();
    do_store(NW - 1, 32'hCAFE_000F);
    do_store(0, 32'hCAFE_0000);
    do_commit("R7 sparse");

    // R8: flags cleared after commit
    tx_open();
    do_load(4, "R8 pre");
    do_store(6, 32'h6666_0006);
    do_commit("R8");
    tx_open();
    do_snoop(4, 32'h4444_0004, "R8 read set cleared");
    do_snoop(6, 32'h4444_0006, "R8 write set cleared");
    do_load(6, "R8 snoop after commit");
    do_abort("R8");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule